// File: doc/BRIEF.md
# Power-Up Reset and Clock-Ready Sequencer

This block owns the chip-wide system reset during supply ramp and recovery, and it decides when the core may see a clock. It takes two digitised supply indications: one says the supply is above the power-on level and the other says it is above the brown-out level. A single state machine then runs through a series of timed stages. The first holds reset until the power-on indication is settled. The next waits out the brown-out delay and then a programmable power-up timer. After that the oscillator is enabled, and the machine waits through whichever start-up stages the selected oscillator mode needs: an analog start-up delay, a 1024-cycle start-up timer and a PLL lock wait. When these are done it declares the clock ready. After a further delay it enables the fail-safe clock monitor, but only if that monitor is configured.

All delays are counted on a one-cycle reference tick (`tick_i`), except the start-up timer, which counts pulses of the oscillator itself (`osc_tick_i`). A power-on or brown-out event is a cold reset, and it reloads the active clock mode from the configuration input. A warm reset request pulses the system reset for one cycle. It keeps the running clock and the active mode.

Top module: `boot_sequencer`

## Requirements
- R1: While `rst_ni` is low, and afterwards while `por_ok_i` is low, `sys_rst_o` is 1 and `osc_en_o`, `clk_ready_o` and `fscm_en_o` are 0.
- R2: With both indications high, `sys_rst_o` is held for POR_TICKS ticks of the power-on stage. It is then held for BOR_TICKS ticks of the brown-out stage. Neither stage counts while its indication is low.
- R3: After the brown-out stage, the power-up timer holds `sys_rst_o` for MS_TICKS×{0,2,4,8,16,32,64,128} ticks for `pwrt_sel_i` codes 0..7. Code 0 skips the stage.
- R4: A low `bor_ok_i` at any point after the power-on stage asserts `sys_rst_o` on the next cycle. The full brown-out plus power-up delay then restarts from zero when the indication returns high.
- R5: `osc_en_o` rises on the cycle `sys_rst_o` falls. `clk_ready_o` follows after the stages of the mode. Mode codes: 0 internal RC (start-up delay), 1 internal RC with PLL, 2 crystal, 3 crystal with PLL, 4 external clock (no stage), 5 external clock with PLL, 6 secondary crystal, 7 low-power RC (start-up delay). The start-up delay lasts OSCD_TICKS and applies to every mode except 4 and 5.
- R6: Modes 2, 3 and 6 add a start-up timer of OST_CYCLES (1024) `osc_tick_i` pulses after the start-up delay.
- R7: Modes 1, 3 and 5 add a final LOCK_TICKS lock wait. Mode 5 uses only the lock wait.
- R8: A cold reset (power-on or brown-out) loads `cfg_mode_i` into `mode_o` when `sys_rst_o` is released. A warm reset leaves `mode_o` unchanged.
- R9: A `warm_req_i` pulse while the clock is ready sets `sys_rst_o` for exactly one cycle. `clk_ready_o` and `osc_en_o` stay high during that cycle.
- R10: `fscm_en_o` rises FSCM_TICKS ticks after `clk_ready_o` (or after the end of a warm reset), and only when `fscm_cfg_i` is 1. Any reset clears it.
- R11: A fall of `por_ok_i` in any stage returns the machine to the power-on hold on the next cycle. In that cycle `sys_rst_o` is 1 and the oscillator and clock-ready outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick for delay counting |
| osc_tick_i | input | 1 | One pulse per oscillator cycle |
| por_ok_i | input | 1 | Supply above power-on level |
| bor_ok_i | input | 1 | Supply above brown-out level |
| warm_req_i | input | 1 | Warm reset request (any non-supply source) |
| pwrt_sel_i | input | 3 | Power-up timer code |
| cfg_mode_i | input | 3 | Configured oscillator mode |
| fscm_cfg_i | input | 1 | Fail-safe clock monitor configured |
| sys_rst_o | output | 1 | System reset, active high |
| osc_en_o | output | 1 | Oscillator enable |
| clk_ready_o | output | 1 | Clock released to the core |
| fscm_en_o | output | 1 | Fail-safe clock monitor enable |
| mode_o | output | 3 | Active oscillator mode |

## Verification
A wrong stage order or a wrong per-mode stage set shows up as a release or clock-ready edge that lands a whole number of stage lengths away from the expected cycle. The bench measures those edges to the exact cycle for each mode and each timer code. A stale counter left over after a supply dip appears as a release that comes early after the indication returns. A wrongly reloaded or wrongly kept mode is visible on `mode_o` as soon as reset is released. Power-on loss and warm reset mistakes show up one cycle after the stimulus.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR, ST_BOR, ST_PWRT, ST_OSCD, ST_OST, ST_LOCK, ST_RUN, ST_WARM
  } seq_state_e;

  typedef struct packed {
    logic oscd;
    logic ost;
    logic pll;
  } mode_flags_t;

  function automatic int unsigned imax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/osc_mode_dec.sv
`timescale 1ns/1ps
module osc_mode_dec
  import boot_seq_pkg::*;
(
  input  logic [2:0]  mode_i,
  output mode_flags_t flags_o
);
  always_comb begin
    unique case (mode_i)
      3'd0:    flags_o = '{oscd: 1'b1, ost: 1'b0, pll: 1'b0};
      3'd1:    flags_o = '{oscd: 1'b1, ost: 1'b0, pll: 1'b1};
      3'd2:    flags_o = '{oscd: 1'b1, ost: 1'b1, pll: 1'b0};
      3'd3:    flags_o = '{oscd: 1'b1, ost: 1'b1, pll: 1'b1};
      3'd4:    flags_o = '{oscd: 1'b0, ost: 1'b0, pll: 1'b0};
      3'd5:    flags_o = '{oscd: 1'b0, ost: 1'b0, pll: 1'b1};
      3'd6:    flags_o = '{oscd: 1'b1, ost: 1'b1, pll: 1'b0};
      default: flags_o = '{oscd: 1'b1, ost: 1'b0, pll: 1'b0};
    endcase
  end
endmodule

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] target_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  // done on the increment that reaches target (target >= 1)
  assign done_o = inc_i && (cnt_q == target_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + W'(1);
  end

  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned POR_TICKS  = 3,
  parameter int unsigned BOR_TICKS  = 4,
  parameter int unsigned MS_TICKS   = 2,
  parameter int unsigned OSCD_TICKS = 5,
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned LOCK_TICKS = 6,
  parameter int unsigned FSCM_TICKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             osc_tick_i,
  input  logic             por_ok_i,
  input  logic             bor_ok_i,
  input  logic             warm_req_i,
  input  logic [2:0]       pwrt_sel_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             fscm_cfg_i,
  input  mode_flags_t      flags_i,
  input  logic             stage_done_i,
  output logic [2:0]       eff_mode_o,
  output logic             tmr_clr_o,
  output logic             tmr_inc_o,
  output logic [CNT_W-1:0] tmr_target_o,
  output logic             sys_rst_o,
  output logic             osc_en_o,
  output logic             clk_ready_o,
  output logic             fscm_en_o,
  output logic [2:0]       mode_o
);
  seq_state_e state_q, state_d;
  logic [2:0] mode_q;
  logic       fscm_q;
  logic       in_hold, leave_hold;

  function automatic seq_state_e after_stage(seq_state_e s, mode_flags_t f);
    seq_state_e n;
    n = ST_RUN;
    unique case (s)
      ST_BOR, ST_PWRT: n = f.oscd ? ST_OSCD : (f.ost ? ST_OST : (f.pll ? ST_LOCK : ST_RUN));
      ST_OSCD:         n = f.ost ? ST_OST : (f.pll ? ST_LOCK : ST_RUN);
      ST_OST:          n = f.pll ? ST_LOCK : ST_RUN;
      default:         n = ST_RUN;
    endcase
    return n;
  endfunction

  assign in_hold    = (state_q == ST_BOR) || (state_q == ST_PWRT);
  assign eff_mode_o = in_hold ? cfg_mode_i : mode_q;
  assign leave_hold = in_hold && !(state_d inside {ST_POR, ST_BOR, ST_PWRT});

  always_comb begin
    state_d = state_q;
    if (!por_ok_i) begin
      state_d = ST_POR;
    end else if (state_q == ST_POR) begin
      if (stage_done_i) state_d = ST_BOR;
    end else if (!bor_ok_i) begin
      state_d = ST_BOR;
    end else begin
      unique case (state_q)
        ST_BOR: if (stage_done_i)
                  state_d = (pwrt_sel_i == 3'd0) ? after_stage(ST_BOR, flags_i) : ST_PWRT;
        ST_PWRT, ST_OSCD, ST_OST, ST_LOCK:
                if (stage_done_i) state_d = after_stage(state_q, flags_i);
        ST_RUN:  if (warm_req_i) state_d = ST_WARM;
        ST_WARM: state_d = ST_RUN;
        default: state_d = ST_POR;
      endcase
    end
  end

  assign tmr_clr_o = (state_d != state_q) || !por_ok_i ||
                     ((state_q != ST_POR) && !bor_ok_i);

  always_comb begin
    unique case (state_q)
      ST_POR:  tmr_inc_o = tick_i && por_ok_i;
      ST_BOR:  tmr_inc_o = tick_i && bor_ok_i;
      ST_OST:  tmr_inc_o = osc_tick_i;
      ST_RUN:  tmr_inc_o = tick_i && !fscm_q;
      ST_WARM: tmr_inc_o = 1'b0;
      default: tmr_inc_o = tick_i;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_POR:  tmr_target_o = CNT_W'(POR_TICKS);
      ST_BOR:  tmr_target_o = CNT_W'(BOR_TICKS);
      ST_PWRT: tmr_target_o = CNT_W'(MS_TICKS) << pwrt_sel_i;
      ST_OSCD: tmr_target_o = CNT_W'(OSCD_TICKS);
      ST_OST:  tmr_target_o = CNT_W'(OST_CYCLES);
      ST_LOCK: tmr_target_o = CNT_W'(LOCK_TICKS);
      ST_RUN:  tmr_target_o = CNT_W'(FSCM_TICKS);
      default: tmr_target_o = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_POR;
      mode_q  <= 3'd0;
      fscm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (leave_hold) mode_q <= cfg_mode_i;
      if (state_d != ST_RUN)
        fscm_q <= 1'b0;
      else if (state_q == ST_RUN && stage_done_i && fscm_cfg_i)
        fscm_q <= 1'b1;
    end
  end

  assign sys_rst_o   = state_q inside {ST_POR, ST_BOR, ST_PWRT, ST_WARM};
  assign osc_en_o    = state_q inside {ST_OSCD, ST_OST, ST_LOCK, ST_RUN, ST_WARM};
  assign clk_ready_o = state_q inside {ST_RUN, ST_WARM};
  assign fscm_en_o   = fscm_q && fscm_cfg_i;
  assign mode_o      = mode_q;

  // R11
  por_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> sys_rst_o && !osc_en_o && !clk_ready_o);
  // R4
  bor_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bor_ok_i |=> sys_rst_o);
  // R5
  ready_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ready_o |-> osc_en_o);
  // R5
  release_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> osc_en_o);
  // R8
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(sys_rst_o));
  // R9
  warm_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_req_i && clk_ready_o && !sys_rst_o && por_ok_i && bor_ok_i)
      |=> sys_rst_o && clk_ready_o && osc_en_o);
  // R10
  fscm_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fscm_en_o |-> clk_ready_o && !sys_rst_o);
endmodule

// File: rtl/boot_sequencer.sv
`timescale 1ns/1ps
module boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter int unsigned POR_TICKS  = 3,
  parameter int unsigned BOR_TICKS  = 4,
  parameter int unsigned MS_TICKS   = 2,
  parameter int unsigned OSCD_TICKS = 5,
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned LOCK_TICKS = 6,
  parameter int unsigned FSCM_TICKS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       osc_tick_i,
  input  logic       por_ok_i,
  input  logic       bor_ok_i,
  input  logic       warm_req_i,
  input  logic [2:0] pwrt_sel_i,
  input  logic [2:0] cfg_mode_i,
  input  logic       fscm_cfg_i,
  output logic       sys_rst_o,
  output logic       osc_en_o,
  output logic       clk_ready_o,
  output logic       fscm_en_o,
  output logic [2:0] mode_o
);
  localparam int unsigned MAX_V = imax(imax(imax(POR_TICKS, BOR_TICKS), imax(MS_TICKS * 128, OSCD_TICKS)),
                                       imax(imax(OST_CYCLES, LOCK_TICKS), FSCM_TICKS));
  localparam int unsigned CNT_W = $clog2(MAX_V + 1);

  mode_flags_t      flags;
  logic [2:0]       eff_mode;
  logic             tmr_clr, tmr_inc, tmr_done;
  logic [CNT_W-1:0] tmr_target;

  osc_mode_dec u_dec (
    .mode_i  (eff_mode),
    .flags_o (flags)
  );

  seq_timer #(.W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .inc_i    (tmr_inc),
    .target_i (tmr_target),
    .done_o   (tmr_done)
  );

  seq_ctrl #(
    .CNT_W(CNT_W), .POR_TICKS(POR_TICKS), .BOR_TICKS(BOR_TICKS), .MS_TICKS(MS_TICKS),
    .OSCD_TICKS(OSCD_TICKS), .OST_CYCLES(OST_CYCLES), .LOCK_TICKS(LOCK_TICKS),
    .FSCM_TICKS(FSCM_TICKS)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .osc_tick_i   (osc_tick_i),
    .por_ok_i     (por_ok_i),
    .bor_ok_i     (bor_ok_i),
    .warm_req_i   (warm_req_i),
    .pwrt_sel_i   (pwrt_sel_i),
    .cfg_mode_i   (cfg_mode_i),
    .fscm_cfg_i   (fscm_cfg_i),
    .flags_i      (flags),
    .stage_done_i (tmr_done),
    .eff_mode_o   (eff_mode),
    .tmr_clr_o    (tmr_clr),
    .tmr_inc_o    (tmr_inc),
    .tmr_target_o (tmr_target),
    .sys_rst_o    (sys_rst_o),
    .osc_en_o     (osc_en_o),
    .clk_ready_o  (clk_ready_o),
    .fscm_en_o    (fscm_en_o),
    .mode_o       (mode_o)
  );
endmodule

// File: tb/boot_sequencer_tb_top.sv
`timescale 1ns/1ps
module boot_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_ni, tick, osc_tick, por_ok, bor_ok, warm_req, fscm_cfg;
  logic [2:0] pwrt_sel, cfg_mode;
  logic sys_rst, osc_en, clk_ready, fscm_en;
  logic [2:0] mode;
  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  boot_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .osc_tick_i(osc_tick),
    .por_ok_i(por_ok), .bor_ok_i(bor_ok), .warm_req_i(warm_req),
    .pwrt_sel_i(pwrt_sel), .cfg_mode_i(cfg_mode), .fscm_cfg_i(fscm_cfg),
    .sys_rst_o(sys_rst), .osc_en_o(osc_en), .clk_ready_o(clk_ready),
    .fscm_en_o(fscm_en), .mode_o(mode)
  );

  // mode, pwrt code, fscm cfg, release cycle, ready cycle, fscm cycle (-1 = never)
  typedef struct packed {
    logic [2:0] m;
    logic [2:0] p;
    logic       f;
    int         rel;
    int         rdy;
    int         fs;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 1'b1,   7,   12,   15},
    '{3'd1, 3'd1, 1'b1,  11,   22,   25},
    '{3'd2, 3'd2, 1'b1,  15, 1044, 1047},
    '{3'd3, 3'd3, 1'b1,  23, 1058, 1061},
    '{3'd4, 3'd6, 1'b1, 135,  135,  138},
    '{3'd5, 3'd7, 1'b1, 263,  269,  272},
    '{3'd6, 3'd4, 1'b0,  39, 1068,   -1},
    '{3'd7, 3'd5, 1'b1,  71,   76,   79}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cold_start(logic [2:0] m, logic [2:0] p, logic f);
    rst_ni = 1'b0;
    cfg_mode = m; pwrt_sel = p; fscm_cfg = f;
    por_ok = 1'b1; bor_ok = 1'b1; warm_req = 1'b0;
    step();
    rst_ni = 1'b1;
  endtask

  task automatic measure(int limit, output int t_rel, output int t_rdy, output int t_fs);
    t_rel = -1; t_rdy = -1; t_fs = -1;
    for (int n = 1; n <= limit; n++) begin
      step();
      if (t_rel < 0 && !sys_rst) t_rel = n;
      if (t_rdy < 0 && clk_ready) t_rdy = n;
      if (t_fs < 0 && fscm_en) t_fs = n;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int rl, rd, fs;
    int bad;
    rst_ni = 1'b0; tick = 1'b1; osc_tick = 1'b1; por_ok = 1'b1; bor_ok = 1'b1;
    warm_req = 1'b0; pwrt_sel = 3'd0; cfg_mode = 3'd0; fscm_cfg = 1'b1;
    step(); step();
    // R1 reset state
    chk("R1 sys_rst", int'(sys_rst), 1);
    chk("R1 osc_en", int'(osc_en), 0);
    chk("R1 clk_ready", int'(clk_ready), 0);
    chk("R1 fscm_en", int'(fscm_en), 0);

    // R2 R3 R5 R6 R7 R8 R10: mode/code table
    for (int v = 0; v < NV; v++) begin
      cold_start(VECS[v].m, VECS[v].p, VECS[v].f);
      measure(1100, rl, rd, fs);
      chk("R3 release", rl, VECS[v].rel);
      chk("R5_R6_R7 ready", rd, VECS[v].rdy);
      chk("R10 fscm", fs, VECS[v].fs);
      chk("R8 mode", int'(mode), int'(VECS[v].m));
    end

    // R1 R2: power-on indication held low after reset
    cold_start(3'd0, 3'd0, 1'b1);
    por_ok = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (!sys_rst || osc_en || clk_ready) bad++;
    end
    chk("R1 hold while por low", bad, 0);
    por_ok = 1'b1;
    measure(20, rl, rd, fs);
    chk("R2 release after por", rl, 7);
    chk("R2 ready after por", rd, 12);

    // R4: dip during power-up timer restarts combined delay
    cold_start(3'd0, 3'd2, 1'b1);
    for (int i = 0; i < 10; i++) step();
    bor_ok = 1'b0;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (!sys_rst) bad++;
    end
    chk("R4 held during dip", bad, 0);
    bor_ok = 1'b1;
    measure(30, rl, rd, fs);
    chk("R4 release after dip", rl, 12);
    chk("R4 ready after dip", rd, 17);

    // R9 R8 R10: warm reset keeps clock and mode
    cold_start(3'd0, 3'd0, 1'b1);
    for (int i = 0; i < 20; i++) step();
    chk("R10 fscm before warm", int'(fscm_en), 1);
    cfg_mode = 3'd2;
    warm_req = 1'b1;
    step();
    warm_req = 1'b0;
    chk("R9 warm sys_rst", int'(sys_rst), 1);
    chk("R9 warm clk_ready", int'(clk_ready), 1);
    chk("R9 warm osc_en", int'(osc_en), 1);
    chk("R8 warm keeps mode", int'(mode), 0);
    chk("R10 fscm cleared by warm", int'(fscm_en), 0);
    step();
    chk("R9 one-cycle pulse", int'(sys_rst), 0);
    measure(5, rl, rd, fs);
    chk("R10 fscm after warm", fs, 3);

    // R4 R8: brown-out in run is cold, reloads mode
    bor_ok = 1'b0;
    step();
    chk("R4 bor in run", int'(sys_rst), 1);
    step();
    bor_ok = 1'b1;
    measure(1100, rl, rd, fs);
    chk("R4 release after run dip", rl, 4);
    chk("R6 ready after run dip", rd, 1033);
    chk("R8 cold reload", int'(mode), 2);

    // R11: power-on loss in run
    por_ok = 1'b0;
    step();
    chk("R11 sys_rst", int'(sys_rst), 1);
    chk("R11 osc_en", int'(osc_en), 0);
    chk("R11 clk_ready", int'(clk_ready), 0);
    por_ok = 1'b1;
    measure(1100, rl, rd, fs);
    chk("R11 restart release", rl, 7);
    chk("R11 restart ready", rd, 1036);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule